// File: doc/BRIEF.md
# Register-Triggered Configuration Bus Controller

This block lets a processor run one read or one write at a time against a remote configuration function. The function is named by five address fields packed into a single command word. Three word registers make up the programming model. Software loads the data register and zeroes the status register. It then writes the command word with its top bit set, and that write launches the transaction. The block keeps the top bit set while the request is outstanding.

When the remote side acknowledges, the block ends the transaction and posts completion in the status register. A failed acknowledge, or a request that goes unanswered for a parameterised number of cycles, posts completion with the fault flag also set. A successful read loads the returned word into the data register.

The remote side is modelled as a request/acknowledge port. A request holds steady while it is valid. The acknowledge is a one-cycle pulse that carries read data and an error flag. The default timeout covers a host that polls about every 100 microseconds for about 100 polls at a 200 MHz clock.

Top module: `cfgbus_ctrl`

## Requirements
- R1: The data register sits at byte offset 0xA0, the command word at 0xA4 and the status register at 0xA8. Reads return the stored contents, and any other offset reads as zero.
- R2: Command word fields are decoded as follows, and while a request is valid they appear unchanged on the request port:
  - bit 31: start
  - bit 30: direction (1 = write, 0 = read)
  - bits 29:26: controller number
  - bits 25:20: function
  - bits 17:16: site
  - bits 15:12: position
  - bits 11:0: device
- R3: A command write with bit 31 = 1 while idle launches a transaction. Bit 31 then reads back as 1, and the request is valid from the next cycle until the transaction ends. A command write with bit 31 = 0 only stores the word.
- R4: A command-word write while bit 31 is set is ignored, and the running request is not disturbed.
- R5: On an acknowledge, bit 31 clears and status bit 0 (complete) sets in the same cycle.
- R6: A read that is acknowledged without error replaces the data register with the returned word.
- R7: A write drives the data register onto the request's outgoing data and leaves the data register unchanged.
- R8: An acknowledge with the error flag set gives status 0b11. On a read, the data register keeps its prior value.
- R9: A request that gets no acknowledge for TIMEOUT_CYC cycles ends with status 0b11, and the request drops after exactly TIMEOUT_CYC valid cycles.
- R10: Reset sets the data, command and status registers to zero.
- R11: Software writes to status store bits 1:0. While a transaction runs, status holds the value software left there until the end.
- R12: Writes to the data register while a transaction runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| rq_valid | output | 1 | Remote request outstanding |
| rq_write | output | 1 | Request direction, 1 = write |
| rq_ctl | output | 4 | Controller number |
| rq_func | output | 6 | Function field |
| rq_site | output | 2 | Site field |
| rq_pos | output | 4 | Position field |
| rq_dev | output | 12 | Device number |
| rq_wdata | output | 32 | Outgoing data for writes |
| rsp_ack | input | 1 | One-cycle acknowledge from the remote side |
| rsp_err | input | 1 | Error flag, qualified by rsp_ack |
| rsp_rdata | input | 32 | Read data, qualified by rsp_ack |

## Verification
The assertions assume the remote side raises rsp_ack only while rq_valid is high, as a single-cycle pulse, and that rsp_err and rsp_rdata are meaningful only in that cycle. The bench's behavioural responder keeps to this. It counts a configurable latency from the first valid cycle, pulses the acknowledge once, and drops it before the request can relaunch. It can also stay silent to force the timeout. Host register traffic is driven half a cycle away from the rising edge, so a write whose only purpose is to be ignored lands while the request is plainly in flight.

// File: rtl/cfgbus_pkg.sv
`timescale 1ns/100ps
package cfgbus_pkg;

    localparam int WORD_W   = 32;
    localparam int DATA_OFS = 'hA0;
    localparam int CMD_OFS  = 'hA4;
    localparam int STAT_OFS = 'hA8;

    typedef struct packed {
        logic        start;
        logic        wr;
        logic [3:0]  ctl_num;
        logic [5:0]  func;
        logic [1:0]  spare;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cmd_word_t;

    typedef struct packed {
        logic [3:0]  ctl_num;
        logic [5:0]  func;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } target_t;

    typedef struct packed {
        logic fault;
        logic done;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_CMD,
        SEL_STAT
    } reg_sel_e;

    function automatic target_t target_of(input cmd_word_t c);
        target_t t;
        t.ctl_num = c.ctl_num;
        t.func    = c.func;
        t.site    = c.site;
        t.pos     = c.pos;
        t.dev     = c.dev;
        return t;
    endfunction

endpackage

// File: rtl/cfgbus_decode.sv
`timescale 1ns/100ps
module cfgbus_decode
    import cfgbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    always_comb begin
        if (addr == A_DATA)      sel = SEL_DATA;
        else if (addr == A_CMD)  sel = SEL_CMD;
        else if (addr == A_STAT) sel = SEL_STAT;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/cfgbus_timer.sv
`timescale 1ns/100ps
module cfgbus_timer #(
    parameter int LIMIT = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic done,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (run && !done) cnt_q <= cnt_q + 1'b1;
        else                  cnt_q <= '0;
    end

    assign expire = run && (cnt_q == CW'(LIMIT - 1));

    // R9: the counter never passes the limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LIMIT));

    // R9: an idle cycle leaves the counter cleared
    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/cfgbus_ctrl.sv
`timescale 1ns/100ps
module cfgbus_ctrl
    import cfgbus_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int TIMEOUT_CYC = 2_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rq_valid,
    output logic              rq_write,
    output logic [3:0]        rq_ctl,
    output logic [5:0]        rq_func,
    output logic [1:0]        rq_site,
    output logic [3:0]        rq_pos,
    output logic [11:0]       rq_dev,
    output logic [31:0]       rq_wdata,
    input  logic              rsp_ack,
    input  logic              rsp_err,
    input  logic [31:0]       rsp_rdata
);
    cmd_word_t          cmd_q;
    logic [WORD_W-1:0]  data_q;
    stat_t              stat_q;
    reg_sel_e           sel;
    logic               busy, expire, finish, fault;
    target_t            tgt;

    cfgbus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign busy   = cmd_q.start;
    assign finish = busy && (rsp_ack || expire);
    assign fault  = rsp_ack ? rsp_err : 1'b1;

    cfgbus_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .done   (finish),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
            stat_q <= '0;
        end else begin
            if (bus_wr && sel == SEL_DATA && !busy) data_q <= bus_wdata;
            if (bus_wr && sel == SEL_CMD && !busy)  cmd_q  <= cmd_word_t'(bus_wdata);
            if (bus_wr && sel == SEL_STAT)          stat_q <= stat_t'(bus_wdata[1:0]);
            if (finish) begin
                cmd_q.start <= 1'b0;
                stat_q      <= stat_t'({fault, 1'b1});
                if (!cmd_q.wr && !fault) data_q <= rsp_rdata;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = data_q;
            SEL_CMD:  bus_rdata = cmd_q;
            SEL_STAT: bus_rdata = {30'd0, stat_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign tgt      = target_of(cmd_q);
    assign rq_valid = busy;
    assign rq_write = cmd_q.wr;
    assign rq_ctl   = tgt.ctl_num;
    assign rq_func  = tgt.func;
    assign rq_site  = tgt.site;
    assign rq_pos   = tgt.pos;
    assign rq_dev   = tgt.dev;
    assign rq_wdata = data_q;

    // R3: a running request stays up until it is answered or times out
    p_hold_busy_r3: assert property (@(posedge clk) disable iff (rst)
        busy && !rsp_ack && !expire |=> rq_valid);

    // R4: command writes during a transaction change nothing
    p_ignore_cmd_r4: assert property (@(posedge clk) disable iff (rst)
        busy && bus_wr && sel == SEL_CMD && !rsp_ack && !expire
        |=> cmd_q == $past(cmd_q));

    // R5: acknowledge ends the transaction and posts completion together
    p_finish_r5: assert property (@(posedge clk) disable iff (rst)
        busy && rsp_ack |=> !rq_valid && stat_q.done);

    // R6: clean read returns the remote word
    p_read_data_r6: assert property (@(posedge clk) disable iff (rst)
        busy && rsp_ack && !rsp_err && !cmd_q.wr |=> data_q == $past(rsp_rdata));

    // R8: faulted acknowledge keeps data and flags both status bits
    p_fault_r8: assert property (@(posedge clk) disable iff (rst)
        busy && rsp_ack && rsp_err |=> stat_q == 2'b11 && $stable(data_q));

    // R9: silent remote side ends in fault
    p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        busy && !rsp_ack && expire |=> stat_q == 2'b11 && !rq_valid);

    // R11: status holds while the transaction runs
    p_stat_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        busy && !finish && !(bus_wr && sel == SEL_STAT) |=> $stable(stat_q));

    // R12: data writes during a transaction are dropped
    p_data_locked_r12: assert property (@(posedge clk) disable iff (rst)
        busy && !finish |=> $stable(data_q));
endmodule

// File: tb/sim_cfgbus_ctrl.sv
`timescale 1ns/100ps
module sim_cfgbus_ctrl;
    localparam int T_OUT = 40;
    localparam logic [7:0] A_DATA = 8'hA0, A_CMD = 8'hA4, A_STAT = 8'hA8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rq_valid, rq_write;
    logic [3:0]  rq_ctl, rq_pos;
    logic [5:0]  rq_func;
    logic [1:0]  rq_site;
    logic [11:0] rq_dev;
    logic [31:0] rq_wdata;
    logic        rsp_ack = 1'b0;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    // responder settings
    bit          resp_on = 1'b1;
    int          resp_lat = 3;
    bit          resp_fault = 1'b0;
    logic [31:0] resp_word = '0;
    int          wait_c = 0;

    assign rsp_err   = resp_fault;
    assign rsp_rdata = resp_word;

    always #2.5 clk = ~clk;

    cfgbus_ctrl #(.ADDR_W(8), .TIMEOUT_CYC(T_OUT)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rq_valid(rq_valid),
        .rq_write(rq_write), .rq_ctl(rq_ctl), .rq_func(rq_func),
        .rq_site(rq_site), .rq_pos(rq_pos), .rq_dev(rq_dev),
        .rq_wdata(rq_wdata), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_data = '0, m_cmd = '0;
    logic [1:0]  m_stat = '0;
    int          m_cnt = 0;

    always @(posedge clk) begin
        bit fin, flt, busy;
        if (rst) begin
            m_data = '0; m_cmd = '0; m_stat = '0; m_cnt = 0;
        end else begin
            busy = m_cmd[31];
            fin = 1'b0; flt = 1'b0;
            if (busy) begin
                if (rsp_ack) begin fin = 1'b1; flt = rsp_err; end
                else if (m_cnt == T_OUT - 1) begin fin = 1'b1; flt = 1'b1; end
            end
            m_cnt = (busy && !fin) ? m_cnt + 1 : 0;
            if (bus_wr && bus_addr == A_DATA && !busy) m_data = bus_wdata;
            if (bus_wr && bus_addr == A_CMD && !busy)  m_cmd  = bus_wdata;
            if (bus_wr && bus_addr == A_STAT)          m_stat = bus_wdata[1:0];
            if (fin) begin
                if (!m_cmd[30] && !flt) m_data = rsp_rdata;
                m_cmd[31] = 1'b0;
                m_stat = {flt, 1'b1};
            end
        end
    end

    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (!rst) begin
            case (bus_addr)
                A_DATA:  exp_rd = m_data;
                A_CMD:   exp_rd = m_cmd;
                A_STAT:  exp_rd = {30'd0, m_stat};
                default: exp_rd = '0;
            endcase
            chk("R1 model readback", bus_rdata, exp_rd);
            chk("R3 model request valid", {31'd0, rq_valid}, {31'd0, m_cmd[31]});
            if (m_cmd[31]) begin
                chk("R2 model fields",
                    {rq_write, rq_ctl, rq_func, rq_site, rq_pos, rq_dev},
                    {m_cmd[30:20], m_cmd[17:0]});
                chk("R7 model outgoing data", rq_wdata, m_data);
            end
        end
    end

    // responder
    always @(negedge clk) begin
        #0.3;
        if (rsp_ack) begin
            rsp_ack = 1'b0;
            wait_c = 0;
        end else if (rq_valid && resp_on) begin
            if (wait_c >= resp_lat) rsp_ack = 1'b1;
            else wait_c++;
        end else begin
            wait_c = 0;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #0.5;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); #0.5;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.2;
        d = bus_rdata;
    endtask

    task automatic wait_done(output logic [31:0] st);
        for (int i = 0; i < 500; i++) begin
            rd(A_STAT, st);
            if (st != 0) break;
            @(negedge clk); #0.5;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, st, cmdw, rd_cmd;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); #0.5;
        rst = 1'b0;

        // R10: reset state
        rd(A_DATA, v); chk("R10 data after reset", v, 32'h0);
        rd(A_CMD, v);  chk("R10 command after reset", v, 32'h0);
        rd(A_STAT, v); chk("R10 status after reset", v, 32'h0);

        // R1 / R3: plain register storage, no launch
        wr(A_DATA, 32'h1234_5678);
        rd(A_DATA, v); chk("R1 data readback", v, 32'h1234_5678);
        wr(A_CMD, 32'h0ABC_DEF0);
        rd(A_CMD, v);  chk("R1 command readback", v, 32'h0ABC_DEF0);
        chk("R3 no launch without start", {31'd0, rq_valid}, 32'h0);
        rd(8'h00, v);  chk("R1 unmapped offset", v, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk("R11 status stores low bits", v, 32'h2);
        wr(A_STAT, 32'h0);

        // write transaction: R2 R3 R4 R5 R7 R11 R12
        wr(A_DATA, 32'hCAFE_F00D);
        resp_lat = 10; resp_fault = 1'b0; resp_word = 32'h5555_AAAA;
        cmdw = {1'b1, 1'b1, 4'd5, 6'h2A, 2'b00, 2'd2, 4'd9, 12'h123};
        wr(A_CMD, cmdw);
        rd(A_CMD, v);  chk("R3 start reads back set", v, cmdw);
        chk("R2 site on port", {30'd0, rq_site}, 32'd2);
        chk("R2 device on port", {20'd0, rq_dev}, 32'h123);
        chk("R2 function on port", {26'd0, rq_func}, 32'h2A);
        chk("R7 outgoing data", rq_wdata, 32'hCAFE_F00D);
        rd(A_STAT, v); chk("R11 status zero while running", v, 32'h0);
        wr(A_CMD, 32'h4000_0FFF);
        rd(A_CMD, v);  chk("R4 command write ignored", v, cmdw);
        chk("R4 request still valid", {31'd0, rq_valid}, 32'h1);
        wr(A_DATA, 32'h0000_0001);
        rd(A_DATA, v); chk("R12 data write ignored", v, 32'hCAFE_F00D);
        wait_done(st);
        rd(A_CMD, rd_cmd);
        chk("R5 status complete", st, 32'h1);
        chk("R5 start cleared same cycle", {31'd0, rd_cmd[31]}, 32'h0);
        rd(A_DATA, v); chk("R7 data kept after write", v, 32'hCAFE_F00D);

        // clean read: R6
        wr(A_STAT, 32'h0);
        resp_lat = 3; resp_word = 32'h0BAD_C0DE;
        wr(A_CMD, {1'b1, 1'b0, 4'd1, 6'h03, 2'b00, 2'd1, 4'd2, 12'hABC});
        chk("R2 read direction on port", {31'd0, rq_write}, 32'h0);
        wait_done(st);
        chk("R6 read status", st, 32'h1);
        rd(A_DATA, v); chk("R6 read data loaded", v, 32'h0BAD_C0DE);

        // faulted read: R8
        wr(A_STAT, 32'h0);
        resp_fault = 1'b1; resp_word = 32'h7777_7777;
        wr(A_CMD, {1'b1, 1'b0, 4'd2, 6'h11, 2'b00, 2'd3, 4'd4, 12'h00F});
        wait_done(st);
        chk("R8 fault status", st, 32'h3);
        rd(A_DATA, v); chk("R8 data unchanged on fault", v, 32'h0BAD_C0DE);

        // timeout: R9
        wr(A_STAT, 32'h0);
        resp_fault = 1'b0; resp_on = 1'b0;
        wr(A_CMD, {1'b1, 1'b0, 4'd0, 6'h01, 2'b00, 2'd0, 4'd0, 12'h001});
        n = 0;
        for (int i = 0; i < 500; i++) begin
            rd(A_STAT, st);
            if (st != 0) break;
            if (rq_valid) n++;
            @(negedge clk); #0.5;
        end
        chk("R9 timeout status", st, 32'h3);
        chk("R9 valid cycles before timeout", n, T_OUT);
        rd(A_CMD, v);  chk("R9 start cleared", {31'd0, v[31]}, 32'h0);
        rd(A_DATA, v); chk("R9 data unchanged", v, 32'h0BAD_C0DE);
        resp_on = 1'b1;

        // R10: reset mid-stream clears everything
        wr(A_CMD, {1'b1, 1'b1, 4'd3, 6'h05, 2'b00, 2'd1, 4'd1, 12'h010});
        rst = 1'b1;
        @(negedge clk); #0.5;
        rst = 1'b0;
        rd(A_CMD, v);  chk("R10 command after late reset", v, 32'h0);
        rd(A_DATA, v); chk("R10 data after late reset", v, 32'h0);
        rd(A_STAT, v); chk("R10 status after late reset", v, 32'h0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule